// File: doc/BRIEF.md
# Request Stream Beat Formatter

This block takes one request at a time, made of a four-Dword header descriptor, a payload of up to `MAX_PAY_DW` Dwords, a payload length in Dwords, first and last byte enables and a six-bit sequence tag. It turns that request into beats on a 512-bit valid/ready stream. Each beat carries data, a 16-bit Dword keep mask, an end-of-packet flag and a sideband word. The sideband word holds the byte enables, a payload offset, the sequence tag, an abort flag and one odd parity bit per data byte. Only one packet occupies a beat.

A request is taken on `req_start` while `req_busy` is low. The block then presents the packet beat by beat and honours backpressure on `m_tready`. The requester may ask for the packet to be cut short with `req_abort`. The next beat presented after that request is then marked aborted and closes the packet. After the final beat is accepted the block drops back to idle.

Top module: `req_beat_formatter`

## Requirements
- R1: A request is taken only on a clock edge where `req_start` is high and `req_busy` is low. `req_busy` and `m_tvalid` are high from the following cycle until the final beat is accepted. A `req_start` raised while busy has no effect on the packet being sent.
- R2: The Dword stream is the four descriptor Dwords followed by `req_len_dw` payload Dwords (0 to `MAX_PAY_DW`). Beat k, Dword j (bits 32j+31:32j) carries stream Dword 16k+j. Dwords whose keep bit is clear are driven as zero.
- R3: `m_tkeep` is a run of ones starting at bit 0. It is all ones in every beat except the natural final beat, which has exactly (4 + length − 16·k) ones.
- R4: `m_tlast` is high only on the final beat. A packet that fits in one beat has it on its first beat.
- R5: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata`, `m_tkeep`, `m_tlast` and `m_tuser` stay unchanged into the next cycle.
- R6: Sideband bits 3:0 carry the first byte enables. Bits 7:4 carry the last byte enables when the length is two or more Dwords, and zero when the length is zero or one.
- R7: Sideband bits 9:8 (payload offset) are always zero. Bits 15:10 carry the sequence tag. All sideband fields stay constant through the packet.
- R8: Sideband bit 17+i is the odd parity of data byte i (bits 8i+7:8i), so that the byte and its parity bit together hold an odd number of ones.
- R9: A `req_abort` pulse while beat k is presented, or while it waits on backpressure, makes beat k+1 carry sideband bit 16 (abort) together with `m_tlast`, and that beat ends the packet. If beat k is the natural final beat, the pulse is ignored. The abort bit is never set on the first beat.
- R10: Once the abort bit is shown, it and `m_tlast` stay high until that beat is accepted.
- R11: In the cycle after the final beat is accepted, `m_tvalid` is low. A `req_abort` raised while idle has no effect on the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_start | input | 1 | Request strobe, taken while not busy |
| req_busy | output | 1 | High while a packet is being sent |
| req_desc | input | 128 | Header descriptor, Dword 0 in bits 31:0 |
| req_payload | input | MAX_PAY_DW*32 | Payload Dwords, Dword 0 in bits 31:0 |
| req_len_dw | input | LEN_W | Payload length in Dwords |
| req_first_be | input | 4 | First Dword byte enables |
| req_last_be | input | 4 | Last Dword byte enables |
| req_seq | input | 6 | Sequence tag |
| req_abort | input | 1 | Request to cut the current packet short |
| m_tvalid | output | 1 | Beat valid |
| m_tready | input | 1 | Beat ready from the receiver |
| m_tdata | output | 512 | Beat data |
| m_tkeep | output | 16 | Dword keep mask |
| m_tlast | output | 1 | Final beat of the packet |
| m_tuser | output | 81 | Sideband word |

## Verification
Two pairs of events can land in one cycle. The first pair is an abort request and the acceptance of the beat it follows. The second pair is an abort request and the natural final beat, which must swallow the request. The bench fires `req_abort` at random points against random `m_tready`, so some pulses coincide with accepts and some with stalls. Directed packets place the pulse on the first beat, on a single-beat packet and on the last beat of a three-beat packet. Each accepted beat is compared with the beat the bench expects from where the pulse fell, and each stalled cycle is compared with the one before it.

// File: rtl/req_beat_formatter.sv
module req_beat_formatter #(
  parameter int DATA_W     = 512,
  parameter int HDR_DW     = 4,
  parameter int MAX_PAY_DW = 44,
  parameter int SEQ_W      = 6,
  parameter int LEN_W      = $clog2(MAX_PAY_DW + 1),
  parameter int SB_W       = DATA_W / 8 + 17
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_start,
  output logic                    req_busy,
  input  logic [HDR_DW*32-1:0]    req_desc,
  input  logic [MAX_PAY_DW*32-1:0] req_payload,
  input  logic [LEN_W-1:0]        req_len_dw,
  input  logic [3:0]              req_first_be,
  input  logic [3:0]              req_last_be,
  input  logic [SEQ_W-1:0]        req_seq,
  input  logic                    req_abort,
  output logic                    m_tvalid,
  input  logic                    m_tready,
  output logic [DATA_W-1:0]       m_tdata,
  output logic [DATA_W/32-1:0]    m_tkeep,
  output logic                    m_tlast,
  output logic [SB_W-1:0]         m_tuser
);
  localparam int KEEP_W   = DATA_W / 32;
  localparam int NBYTE    = DATA_W / 8;
  localparam int TOT_DW   = HDR_DW + MAX_PAY_DW;
  localparam int NBEATS   = (TOT_DW + KEEP_W - 1) / KEEP_W;
  localparam int BIDX_W   = NBEATS > 1 ? $clog2(NBEATS) : 1;
  localparam int TOT_W    = $clog2(TOT_DW + 1);
  localparam int REM_W    = $clog2(KEEP_W + 1);
  localparam int STREAM_W = TOT_DW * 32;
  localparam int FLAT_W   = NBEATS * DATA_W;

  logic [HDR_DW*32-1:0]     desc_q;
  logic [MAX_PAY_DW*32-1:0] pay_q;
  logic [3:0]               fbe_q, lbe_q;
  logic [SEQ_W-1:0]         seq_q;
  logic [BIDX_W-1:0]        beat_q, lidx_q;
  logic [REM_W-1:0]         rem_q;
  logic                     act_q, ab_q, pend_q;

  logic [TOT_W-1:0] tot_w, lidx_w;
  logic [REM_W-1:0] rem_w;
  assign tot_w  = TOT_W'(HDR_DW) + TOT_W'(req_len_dw);
  assign lidx_w = (tot_w - TOT_W'(1)) / TOT_W'(KEEP_W);
  assign rem_w  = REM_W'(tot_w - lidx_w * TOT_W'(KEEP_W));

  logic take, accept, at_end;
  assign take   = req_start & ~act_q;
  assign accept = act_q & m_tready;
  assign at_end = beat_q == lidx_q;

  always_ff @(posedge clk) begin
    if (take) begin
      desc_q <= req_desc;
      pay_q  <= req_payload;
      fbe_q  <= req_first_be;
      lbe_q  <= (req_len_dw > LEN_W'(1)) ? req_last_be : 4'h0;
      seq_q  <= req_seq;
      lidx_q <= BIDX_W'(lidx_w);
      rem_q  <= rem_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ab_q   <= 1'b0;
      pend_q <= 1'b0;
      beat_q <= '0;
    end else if (!act_q) begin
      ab_q   <= 1'b0;
      pend_q <= 1'b0;
      if (req_start) begin
        act_q  <= 1'b1;
        beat_q <= '0;
      end
    end else if (accept) begin
      pend_q <= 1'b0;
      if (m_tlast) begin
        act_q <= 1'b0;
        ab_q  <= 1'b0;
      end else begin
        beat_q <= beat_q + BIDX_W'(1);
        ab_q   <= pend_q | req_abort;
      end
    end else begin
      pend_q <= pend_q | req_abort;
    end
  end

  logic [FLAT_W-1:0] flat;
  logic [DATA_W-1:0] raw;
  logic [NBYTE-1:0]  par;
  assign flat = FLAT_W'({pay_q, desc_q});
  assign raw  = flat[beat_q*DATA_W +: DATA_W];

  assign m_tkeep = at_end ? ~({KEEP_W{1'b1}} << rem_q) : {KEEP_W{1'b1}};

  for (genvar j = 0; j < KEEP_W; j++) begin : g_dw
    assign m_tdata[j*32 +: 32] = raw[j*32 +: 32] & {32{m_tkeep[j]}};
  end

  for (genvar b = 0; b < NBYTE; b++) begin : g_par
    assign par[b] = ~^m_tdata[b*8 +: 8];
  end

  assign m_tvalid = act_q;
  assign req_busy = act_q;
  assign m_tlast  = act_q & (at_end | ab_q);
  assign m_tuser  = {par, ab_q, seq_q, 2'b00, lbe_q, fbe_q};
endmodule

// File: rtl/req_beat_formatter_chk.sv
module req_beat_formatter_chk #(
  parameter int DATA_W = 512,
  parameter int SB_W   = DATA_W / 8 + 17,
  parameter int AB_BIT = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_start,
  input logic                 req_busy,
  input logic                 m_tvalid,
  input logic                 m_tready,
  input logic                 m_tlast,
  input logic [DATA_W/32-1:0] m_tkeep,
  input logic [DATA_W-1:0]    m_tdata,
  input logic [SB_W-1:0]      m_tuser
);
  logic first_b;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) first_b <= 1'b0;
    else if (req_start && !req_busy) first_b <= 1'b1;
    else if (m_tvalid && m_tready) first_b <= 1'b0;
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tkeep)
      && $stable(m_tlast) && $stable(m_tuser)); // R5
  AST_KEEP_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (m_tkeep != '0) && ((m_tkeep & (m_tkeep + 1'b1)) == '0)); // R3
  AST_KEEP_FULL_MID: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tlast |-> &m_tkeep); // R3
  AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tuser[AB_BIT] |-> m_tlast); // R9
  AST_ABORT_NOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    first_b |-> m_tvalid && !m_tuser[AB_BIT]); // R9
  AST_ABORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tuser[AB_BIT] && !m_tready |=> m_tuser[AB_BIT] && m_tlast); // R10
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tready && m_tlast |=> !m_tvalid); // R11
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_start && !req_busy |=> req_busy && m_tvalid); // R1
endmodule

bind req_beat_formatter req_beat_formatter_chk #(.DATA_W(DATA_W), .SB_W(SB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_busy(req_busy),
  .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
  .m_tkeep(m_tkeep), .m_tdata(m_tdata), .m_tuser(m_tuser)
);

// File: tb/req_beat_formatter_test.sv
`timescale 1ns/1ps
module req_beat_formatter_test;
  localparam int MAXP  = 44;
  localparam int LEN_W = $clog2(MAXP + 1);
  localparam int SB_W  = 81;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_start = 1'b0, req_abort = 1'b0, m_tready = 1'b0;
  logic [127:0] req_desc = '0;
  logic [MAXP*32-1:0] req_payload = '0;
  logic [LEN_W-1:0] req_len_dw = '0;
  logic [3:0] req_first_be = '0, req_last_be = '0;
  logic [5:0] req_seq = '0;
  logic req_busy, m_tvalid, m_tlast;
  logic [511:0] m_tdata;
  logic [15:0] m_tkeep;
  logic [SB_W-1:0] m_tuser;

  always #4 clk = ~clk;

  req_beat_formatter #(.MAX_PAY_DW(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_busy(req_busy),
    .req_desc(req_desc), .req_payload(req_payload), .req_len_dw(req_len_dw),
    .req_first_be(req_first_be), .req_last_be(req_last_be), .req_seq(req_seq),
    .req_abort(req_abort), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast), .m_tuser(m_tuser)
  );

  int nchk = 0, nerr = 0;
  logic [31:0] bdesc [4];
  logic [31:0] bpay [MAXP];
  logic [3:0] bfbe, blbe;
  logic [5:0] bseq;

  task automatic chk(input string req, input logic [599:0] act, input logic [599:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] exp_data(input int k, input int tot);
    logic [511:0] d = '0;
    for (int j = 0; j < 16; j++) begin
      int w = 16 * k + j;
      if (w < tot) d[j*32 +: 32] = (w < 4) ? bdesc[w] : bpay[w-4];
    end
    return d;
  endfunction

  function automatic logic [15:0] exp_keep(input int k, input int tot);
    int n = tot - 16 * k;
    if (n >= 16) return 16'hFFFF;
    return 16'((32'd1 << n) - 1);
  endfunction

  function automatic logic [63:0] exp_par(input logic [511:0] d);
    logic [63:0] p;
    for (int b = 0; b < 64; b++) p[b] = ~^d[b*8 +: 8];
    return p;
  endfunction

  task automatic run_pkt(input int len, input int abort_at, input int rdy_pct);
    int tot, nat, acc, a, cyc, elast;
    bit done, stall, eab;
    logic [511:0] sd, ed;
    logic [15:0] sk;
    logic sl;
    logic [SB_W-1:0] su;
    for (int i = 0; i < 4; i++) bdesc[i] = $urandom;
    for (int i = 0; i < MAXP; i++) bpay[i] = $urandom;
    bfbe = 4'($urandom); blbe = 4'($urandom); bseq = 6'($urandom);
    tot = 4 + len; nat = (tot - 1) / 16;
    req_abort = 1'b1;
    @(negedge clk);
    req_abort = 1'b0;
    for (int i = 0; i < 4; i++) req_desc[i*32 +: 32] = bdesc[i];
    for (int i = 0; i < MAXP; i++) req_payload[i*32 +: 32] = bpay[i];
    req_len_dw = LEN_W'(len); req_first_be = bfbe; req_last_be = blbe; req_seq = bseq;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    chk("R1 busy after start", 600'(req_busy), 600'(1));
    acc = 0; a = -1; cyc = 0; done = 0; stall = 0;
    while (!done) begin
      m_tready = ($urandom % 100) < rdy_pct;
      req_abort = 1'b0;
      if (abort_at >= 0 && a < 0 && acc == abort_at) begin req_abort = 1'b1; a = acc; end
      if (cyc == 1) begin
        req_start = 1'b1; req_desc = ~req_desc; req_len_dw = LEN_W'($urandom % (MAXP + 1));
      end else req_start = 1'b0;
      if (!m_tvalid) begin
        chk("R1 valid held until final beat", 600'(m_tvalid), 600'(1));
        done = 1;
      end else begin
        if (stall) begin
          chk("R5 data held", 600'(m_tdata), 600'(sd));
          chk("R5 keep/last/user held", 600'({m_tkeep, m_tlast, m_tuser}), 600'({sk, sl, su}));
        end
        if (m_tready) begin
          eab = (a >= 0) && (a < nat) && (acc == a + 1);
          elast = (a >= 0 && a < nat) ? a + 1 : nat;
          ed = exp_data(acc, tot);
          chk("R2 beat data", 600'(m_tdata), 600'(ed));
          if (acc == nat) chk("R3 final keep", 600'(m_tkeep), 600'(exp_keep(acc, tot)));
          else chk("R3 full keep", 600'(m_tkeep), 600'(16'hFFFF));
          chk("R4 last flag", 600'(m_tlast), 600'(acc == elast));
          chk("R6 first be", 600'(m_tuser[3:0]), 600'(bfbe));
          chk("R6 last be", 600'(m_tuser[7:4]), 600'(len > 1 ? blbe : 4'h0));
          chk("R7 offset and seq", 600'(m_tuser[15:8]), 600'({bseq, 2'b00}));
          chk("R9 abort bit", 600'(m_tuser[16]), 600'(eab));
          chk("R8 parity", 600'(m_tuser[80:17]), 600'(exp_par(ed)));
          if (acc >= elast) done = 1;
          acc++;
          stall = 0;
        end else begin
          stall = 1; sd = m_tdata; sk = m_tkeep; sl = m_tlast; su = m_tuser;
        end
      end
      @(negedge clk);
      cyc++;
    end
    req_start = 1'b0; req_abort = 1'b0;
    chk("R11 idle after final beat", 600'({m_tvalid, req_busy}), 600'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    repeat (3) @(negedge clk);
    chk("R11 reset state", 600'({m_tvalid, req_busy}), 600'(0));
    rst_n = 1'b1;
    @(negedge clk);
    run_pkt(0, -1, 100);
    run_pkt(1, -1, 100);
    run_pkt(2, -1, 60);
    run_pkt(12, -1, 100);
    run_pkt(13, -1, 50);
    run_pkt(MAXP, -1, 100);
    run_pkt(MAXP, 0, 100);
    run_pkt(5, 0, 100);
    run_pkt(MAXP, 2, 70);
    run_pkt(MAXP, 1, 30);
    run_pkt(28, 0, 20);
    for (int n = 0; n < 60; n++)
      run_pkt($urandom % (MAXP + 1), ($urandom % 3 == 0) ? int'($urandom % 3) : -1,
              20 + $urandom % 81);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule